// File: doc/BRIEF.md
# SPI Bit-Clock and Chip-Select Sequencer

This block produces the serial clock, the chip-select lines and the per-edge strobes for an SPI master that serves up to five attached devices. Each device owns a 32-bit timing word. The word holds a rate code and three reference-clock counts: lead-in before clocking, tail after clocking, and a recovery gap before the next selection. Each device also has its own idle clock level and its own capture phase.

A transfer starts when `start_i` is sampled high while the block is ready and the device index names an existing device. The block latches that device's settings. It drives the device's select line low, waits the lead-in, and then toggles the serial clock at the programmed rate. At every clock edge it pulses either the shift strobe or the sample strobe for the data engine. The data engine raises `done_i` when its byte count is exhausted. The block then finishes the current clock period, holds the select for the tail count, releases it, waits the gap, and becomes ready again.

Top module: `spi_clk_cs_timer`

## Requirements
- R1: While in reset and while idle, every `cs_n_o` line is high, `ready_o` is 1, both strobes are 0, and `sclk_o` equals `cpol_i[dev_sel_i]`, or 0 when `dev_sel_i` is 5 or more.
- R2: While clocking, `sclk_o` toggles every H reference cycles. H is 256/P, and P is the power of two derived from the rate code in bits 31:24 of the device word. The serial rate is therefore the reference rate times P/512.
- R3: The rate code is normalised as follows. 255 means P=256, so H=1 and the serial clock runs at half the reference rate. 0 means P=1, so H=256. Any other value is rounded down to the nearest power of two.
- R4: A start sampled while `ready_o` is 1 and `dev_sel_i` is below 5 drives `cs_n_o[dev_sel_i]` low from the next cycle. The first `sclk_o` edge follows S+H cycles after that edge, where S is bits 23:16 of the device word.
- R5: Only the line of the latched device is ever driven low. A start with `dev_sel_i` of 5 or more is ignored, and `ready_o` stays 1.
- R6: `sclk_o` rests at the device's `cpol_i` bit. With `cpha_i` bit 0, the first edge of each period is a sample edge and the second is a shift edge. With `cpha_i` bit 1, the roles swap. Each strobe is high for exactly the one cycle in which `sclk_o` has just changed.
- R7: `done_i` is examined only at the second edge of each period. Clocking stops after the first period whose second edge sees `done_i` high.
- R8: The select line rises Hd cycles after the last clock edge, where Hd is bits 15:8 of the device word.
- R9: `ready_o` returns D cycles after the select line rises, where D is bits 7:0 of the device word. A start sampled while `ready_o` is 0 is ignored.
- R10: Changes to `dev_sel_i`, `cpol_i`, `cpha_i` or the device words during a transfer do not affect that transfer.
- R11: Any of the lead-in, tail or gap counts may be zero, and a zero count removes that interval entirely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_param_i | input | NUM_DEV*32 | Timing words, device n at bits n*32+31 to n*32 |
| dev_sel_i | input | SEL_W | Index of the device for the next transfer |
| cpol_i | input | NUM_DEV | Idle clock level for each device |
| cpha_i | input | NUM_DEV | Capture phase for each device |
| start_i | input | 1 | Transfer request |
| done_i | input | 1 | Byte count exhausted, from the data engine |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | NUM_DEV | Chip selects, active low |
| shift_stb_o | output | 1 | One-cycle pulse: present the next bit |
| sample_stb_o | output | 1 | One-cycle pulse: capture the incoming bit |
| ready_o | output | 1 | Idle and able to accept a start |

## Verification
The bench drives rate codes 255, 0, 200 and 3 as well as a plain power of two. A design that decoded these codes literally would place the clock edges at the wrong spacing, or would never toggle when the code is zero. The bench drives the zero-interval case and a start held high across back-to-back transfers. An off-by-one in the lead-in, tail or gap counters would move the select edges or the ready edge by one cycle. The bench issues starts while busy and starts with an out-of-range index, and it rewrites polarity, phase and device words mid-transfer. A design that failed to latch its settings would bend the clock in flight or swap its strobes. A design that decoded `done_i` on the wrong edge would end with an odd number of edges and leave the clock at its active level.

// File: rtl/spi_tim_pkg.sv
package spi_tim_pkg;

  localparam int FIELD_W = 8;
  localparam int WORD_W  = 32;

  typedef struct packed {
    logic [FIELD_W-1:0] half_m1;
    logic [FIELD_W-1:0] setup;
    logic [FIELD_W-1:0] hold;
    logic [FIELD_W-1:0] gap;
    logic               cpol;
    logic               cpha;
  } dev_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_RUN, ST_HOLD, ST_GAP
  } seq_st_t;

  // Turn a rate code into the half-period length minus one, in reference cycles.
  function automatic logic [FIELD_W-1:0] half_m1_of(input logic [FIELD_W-1:0] code);
    logic [3:0] k;
    k = 4'd0;
    if (code == 8'hFF) return 8'h00;
    if (code == 8'h00) return 8'hFF;
    for (int i = 0; i < FIELD_W; i++)
      if (code[i]) k = 4'(i);
    return 8'((9'h100 >> k) - 9'h001);
  endfunction

endpackage

// File: rtl/spi_dev_select.sv
module spi_dev_select
  import spi_tim_pkg::*;
#(
  parameter int NUM_DEV = 5,
  parameter int SEL_W   = 3
) (
  input  logic [NUM_DEV*WORD_W-1:0] dev_param_i,
  input  logic [SEL_W-1:0]          sel_i,
  input  logic [NUM_DEV-1:0]        cpol_i,
  input  logic [NUM_DEV-1:0]        cpha_i,
  output logic                      sel_ok_o,
  output dev_cfg_t                  cfg_o,
  output logic                      idle_pol_o
);

  dev_cfg_t cfg_arr [NUM_DEV];

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    logic [WORD_W-1:0] word;
    assign word = dev_param_i[g*WORD_W +: WORD_W];
    assign cfg_arr[g].half_m1 = half_m1_of(word[31:24]);
    assign cfg_arr[g].setup   = word[23:16];
    assign cfg_arr[g].hold    = word[15:8];
    assign cfg_arr[g].gap     = word[7:0];
    assign cfg_arr[g].cpol    = cpol_i[g];
    assign cfg_arr[g].cpha    = cpha_i[g];
  end

  assign sel_ok_o = int'(sel_i) < NUM_DEV;

  always_comb begin
    cfg_o      = '0;
    idle_pol_o = 1'b0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (sel_i == SEL_W'(i)) begin
        cfg_o      = cfg_arr[i];
        idle_pol_o = cpol_i[i];
      end
    end
  end

endmodule

// File: rtl/spi_edge_gen.sv
module spi_edge_gen
  import spi_tim_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               clr_i,
  input  logic [FIELD_W-1:0] half_m1_i,
  input  logic               cpha_i,
  input  logic               done_i,
  output logic               tog_o,
  output logic               last_o,
  output logic               shift_stb_o,
  output logic               sample_stb_o
);

  logic [FIELD_W-1:0] hcnt_q;
  logic               tog_q, lead_q, trail_q;
  logic               edge_now;

  assign edge_now = run_i && (hcnt_q == half_m1_i);
  assign last_o   = edge_now && tog_q && done_i;
  assign tog_o    = tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q  <= '0;
      tog_q   <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      if (!run_i || edge_now) hcnt_q <= '0;
      else                    hcnt_q <= hcnt_q + 8'd1;
      if (clr_i)         tog_q <= 1'b0;
      else if (edge_now) tog_q <= ~tog_q;
      lead_q  <= edge_now && !tog_q;
      trail_q <= edge_now && tog_q;
    end
  end

  assign sample_stb_o = cpha_i ? trail_q : lead_q;
  assign shift_stb_o  = cpha_i ? lead_q  : trail_q;

  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> hcnt_q <= half_m1_i);

  a_r6_lead_alternates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_q |=> !lead_q);

endmodule

// File: rtl/spi_clk_cs_timer.sv
module spi_clk_cs_timer
  import spi_tim_pkg::*;
#(
  parameter int NUM_DEV = 5,
  parameter int SEL_W   = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_DEV*WORD_W-1:0] dev_param_i,
  input  logic [SEL_W-1:0]          dev_sel_i,
  input  logic [NUM_DEV-1:0]        cpol_i,
  input  logic [NUM_DEV-1:0]        cpha_i,
  input  logic                      start_i,
  input  logic                      done_i,
  output logic                      sclk_o,
  output logic [NUM_DEV-1:0]        cs_n_o,
  output logic                      shift_stb_o,
  output logic                      sample_stb_o,
  output logic                      ready_o
);

  dev_cfg_t           cfg_live, cfg_l;
  seq_st_t            st_q;
  logic [FIELD_W-1:0] cnt_q;
  logic [SEL_W-1:0]   dev_l;
  logic               sel_ok, live_pol, accept, cs_on;
  logic               tog, last_edge;

  spi_dev_select #(.NUM_DEV(NUM_DEV), .SEL_W(SEL_W)) u_sel (
    .dev_param_i (dev_param_i),
    .sel_i       (dev_sel_i),
    .cpol_i      (cpol_i),
    .cpha_i      (cpha_i),
    .sel_ok_o    (sel_ok),
    .cfg_o       (cfg_live),
    .idle_pol_o  (live_pol)
  );

  spi_edge_gen u_edge (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (st_q == ST_RUN),
    .clr_i        (st_q == ST_IDLE),
    .half_m1_i    (cfg_l.half_m1),
    .cpha_i       (cfg_l.cpha),
    .done_i       (done_i),
    .tog_o        (tog),
    .last_o       (last_edge),
    .shift_stb_o  (shift_stb_o),
    .sample_stb_o (sample_stb_o)
  );

  assign accept = (st_q == ST_IDLE) && start_i && sel_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      cfg_l <= '0;
      dev_l <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          cfg_l <= cfg_live;
          dev_l <= dev_sel_i;
          if (cfg_live.setup != '0) begin
            st_q  <= ST_SETUP;
            cnt_q <= cfg_live.setup - 8'd1;
          end else begin
            st_q <= ST_RUN;
          end
        end
        ST_SETUP: if (cnt_q == '0) st_q <= ST_RUN;
                  else             cnt_q <= cnt_q - 8'd1;
        ST_RUN: if (last_edge) begin
          if (cfg_l.hold != '0) begin
            st_q  <= ST_HOLD;
            cnt_q <= cfg_l.hold - 8'd1;
          end else if (cfg_l.gap != '0) begin
            st_q  <= ST_GAP;
            cnt_q <= cfg_l.gap - 8'd1;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_HOLD: if (cnt_q != '0) cnt_q <= cnt_q - 8'd1;
                 else if (cfg_l.gap != '0) begin
                   st_q  <= ST_GAP;
                   cnt_q <= cfg_l.gap - 8'd1;
                 end else st_q <= ST_IDLE;
        ST_GAP: if (cnt_q == '0) st_q <= ST_IDLE;
                else             cnt_q <= cnt_q - 8'd1;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_on   = (st_q == ST_SETUP) || (st_q == ST_RUN) || (st_q == ST_HOLD);
  assign ready_o = (st_q == ST_IDLE);
  assign sclk_o  = ready_o ? live_pol : (cfg_l.cpol ^ tog);

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_cs
    assign cs_n_o[g] = !(cs_on && (dev_l == SEL_W'(g)));
  end

  a_r5_single_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_n_o) <= 1);

  a_r4_accept_leaves_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i && sel_ok) |=> !ready_o);

  a_r9_ready_releases_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> &cs_n_o);

  a_r6_strobe_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((shift_stb_o || sample_stb_o) && !ready_o) |-> sclk_o != $past(sclk_o));

  a_r10_device_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |-> $stable(dev_l));

  a_r7_stop_on_trailing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == ST_RUN && st_q != ST_RUN) |-> sclk_o == cfg_l.cpol || ready_o);

endmodule

// File: tb/tb_spi_clk_cs_timer.sv
`timescale 1ns/1ps
module tb_spi_clk_cs_timer;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic [159:0] dev_param = '0;
  logic [2:0]   dev_sel = '0;
  logic [4:0]   cpol = '0, cpha = '0;
  logic         start = 1'b0, done = 1'b0;
  logic         sclk, shift_stb, sample_stb, ready;
  logic [4:0]   cs_n;

  int nchk = 0, nfail = 0;
  int c = 0, t0 = 0, req_n = 1;
  int mS, mH, mHd, mD, mN, mEND, mdev;
  bit mhave = 0, mpol, mpha;
  int code_of [5];

  always #2.5 clk = ~clk;

  spi_clk_cs_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .dev_param_i(dev_param), .dev_sel_i(dev_sel),
    .cpol_i(cpol), .cpha_i(cpha), .start_i(start), .done_i(done),
    .sclk_o(sclk), .cs_n_o(cs_n), .shift_stb_o(shift_stb),
    .sample_stb_o(sample_stb), .ready_o(ready));

  function automatic int half_of(int code);
    int p;
    if (code == 255) return 1;
    p = 1;
    while (p * 2 <= code) p = p * 2;
    return 256 / p;
  endfunction

  function automatic bit m_idle();
    return !mhave || (c - t0 >= mEND);
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, got, exp, c);
    end
  endtask

  // Reference model: advance on each rising edge
  always @(posedge clk) begin
    bit was_idle;
    was_idle = !mhave || ((c - t0) >= mEND);
    c = c + 1;
    if (!rst_n) mhave = 0;
    else if (was_idle && start && dev_sel < 5) begin
      mdev = int'(dev_sel);
      mS   = int'(dev_param[mdev*32+16 +: 8]);
      mHd  = int'(dev_param[mdev*32+8 +: 8]);
      mD   = int'(dev_param[mdev*32 +: 8]);
      mH   = half_of(int'(dev_param[mdev*32+24 +: 8]));
      mpol = cpol[mdev];
      mpha = cpha[mdev];
      mN   = req_n;
      mEND = mS + 2 * mN * mH + mHd + mD;
      t0   = c;
      mhave = 1;
    end
  end

  // Compare every cycle, away from the rising edge; also drive done
  always @(negedge clk) begin
    int r, e, j;
    bit inx, lead;
    logic [4:0] ecs;
    logic esclk, esh, esa;
    string tg;
    r = c - t0;
    inx = mhave && (r < mEND);
    done = inx && (r >= mS + (2 * mN - 1) * mH);
    if (rst_n) begin
      if (!inx) tg = "R1";
      else if (r < mS) tg = "R4";
      else if (r < mS + 2 * mN * mH) tg = "R2";
      else if (r < mS + 2 * mN * mH + mHd) tg = "R8";
      else tg = "R9";
      ecs = 5'h1f;
      if (inx && r < mS + 2 * mN * mH + mHd) ecs = ~(5'b1 << mdev);
      if (inx) begin
        e = (r < mS) ? 0 : (r - mS) / mH;
        if (e > 2 * mN) e = 2 * mN;
        esclk = mpol ^ e[0];
      end else begin
        esclk = (dev_sel < 5) ? cpol[dev_sel] : 1'b0;
      end
      esh = 0; esa = 0;
      if (mhave && r > mS && ((r - mS) % mH) == 0) begin
        j = (r - mS) / mH;
        if (j >= 1 && j <= 2 * mN) begin
          lead = (j % 2) == 1;
          esa = mpha ? !lead : lead;
          esh = !esa;
        end
      end
      chk((!inx && dev_sel >= 5) ? "R5" : tg, "cs_n", int'(cs_n), int'(ecs));
      chk(tg, "ready", int'(ready), int'(!inx));
      chk(inx ? tg : "R1", "sclk", int'(sclk), int'(esclk));
      chk("R6", "shift_stb", int'(shift_stb), int'(esh));
      chk("R6", "sample_stb", int'(sample_stb), int'(esa));
    end
  end

  task automatic set_dev(int n, int code, int s, int hd, int d);
    dev_param[n*32 +: 32] = {code[7:0], s[7:0], hd[7:0], d[7:0]};
    code_of[n] = code;
  endtask

  // One transfer; poke_r >= 0 pulses start (and optionally rewrites config) at that cycle
  task automatic xfer(int dv, int n, string req, int poke_r, bit poke_cfg);
    int nsa, first, second;
    nsa = 0; first = -1; second = -1;
    while (!m_idle()) @(negedge clk);
    dev_sel = 3'(dv); req_n = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while ((c - t0) <= mEND) begin
      if ((c - t0) == poke_r) begin
        start = 1'b1;
        if (poke_cfg) begin
          cpol = ~cpol; cpha = ~cpha; dev_sel = 3'd0;
          dev_param[dv*32+24 +: 8] = 8'h01;
          dev_param[dv*32+8 +: 8] = 8'h09;
        end
      end
      @(negedge clk);
      start = 1'b0;
      if (sample_stb) nsa++;
      if (sample_stb || shift_stb) begin
        if (first < 0) first = c;
        else if (second < 0) second = c;
      end
    end
    chk("R7", {req, " sample count"}, nsa, n);
    chk(req, "edge spacing (R3)", second - first, half_of(code_of[dv]));
  endtask

  initial begin
    set_dev(0, 255, 2, 1, 3);
    set_dev(1, 64, 0, 0, 0);
    set_dev(2, 200, 1, 2, 1);
    set_dev(3, 0, 1, 1, 1);
    set_dev(4, 3, 0, 2, 0);
    cpol = 5'b01010;
    cpha = 5'b00110;
    repeat (3) @(negedge clk);
    chk("R1", "reset cs_n", int'(cs_n), 31);
    chk("R1", "reset ready", int'(ready), 1);
    chk("R1", "reset strobes", int'(shift_stb | sample_stb), 0);
    rst_n = 1'b1;
    @(negedge clk);
    xfer(0, 2, "R4", -1, 0);
    xfer(1, 1, "R11", -1, 0);
    xfer(2, 3, "R3", -1, 0);
    xfer(3, 1, "R3", -1, 0);
    xfer(4, 1, "R6", -1, 0);
    // out-of-range device index is ignored
    dev_sel = 3'd5; start = 1'b1;
    repeat (3) @(negedge clk);
    dev_sel = 3'd7;
    repeat (2) @(negedge clk);
    chk("R5", "ready after bad index", int'(ready), 1);
    chk("R5", "cs_n after bad index", int'(cs_n), 31);
    start = 1'b0;
    xfer(0, 2, "R9", 8, 0);
    xfer(2, 2, "R10", 3, 1);
    // start held high: back-to-back transfers on a zero-interval device
    dev_sel = 3'd1; req_n = 1; start = 1'b1;
    repeat (24) @(negedge clk);
    start = 1'b0;
    while (!m_idle()) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule